// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide, two-address register front end of an eight-line interrupt controller. Software programs the controller through it: an initialization sequence of up to four bytes sets the vector base and the operating modes. Run-time command bytes then perform end-of-interrupt, change the rotating priority offset, pick which status register a read returns, and arm a polled acknowledge. The block holds the mask, the vector base, the rotation offset and the mode flags, and hands them to a separate priority resolver.

The priority scan is not part of this block. The resolver supplies its current winner, the highest-priority line that is in service, and the raw request and in-service registers. The sequencer sends back one-cycle strobes. One tells the resolver to clear a given in-service bit. Another acknowledges a polled line. A third wipes request and in-service state when initialization begins. Read data is combinational from the address, the select flag and the poll state. A write strobe is sampled at the rising clock edge. Reads and writes are not issued in the same cycle.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the mask, the vector base, the rotation offset and every mode flag are zero, and the block is in normal operation, so an address-1 write loads the mask.
- R2: An address-0 write with bit 4 set pulses `init_clr_o` in that cycle. It clears the mask, the vector base, the rotation offset, all mode flags, poll and the read select (back to the request register). It records bit 0 as "fourth byte needed" and bit 1 as single mode (`single_o`), and it makes the next address-1 write the base byte.
- R3: The base byte, an address-1 write, sets `vec_base_o` to its bits 7..3 with bits 2..0 forced to zero.
- R4: After the base byte the next address-1 write is the cascade byte, unless single mode is set. The cascade byte itself has no visible effect. After the base byte in single mode, or after the cascade byte, the next step is the mode byte when the fourth-byte flag is set, and normal operation otherwise.
- R5: The mode byte sets `sfnm_o` from bit 4 and `aeoi_o` from bit 1, then returns to normal operation.
- R6: In normal operation an address-1 write loads `imr_o` with the written byte.
- R7: An address-0 write with bit 4 clear and bit 3 set arms poll when bit 2 is set. When bit 1 is set, bit 0 selects the in-service register (1) or the request register (0) for address-0 reads; with bit 1 clear the select is kept. When bit 6 is set, bit 5 loads `smm_o`; with bit 6 clear `smm_o` is kept.
- R8: With bits 4 and 3 clear, bits 7..5 form a command. Commands 0 and 4 load `rot_aeoi_o` with bit 7.
- R9: Commands 1 and 5 are a nonspecific end-of-interrupt. If `isr_top_valid_i` is set, `eoi_o` pulses in that cycle with `eoi_line_o` = `isr_top_line_i`, and command 5 also sets the rotation offset to that line + 1 (mod 8). If `isr_top_valid_i` is clear, there is no pulse and no change.
- R10: Commands 3 and 7 pulse `eoi_o` with `eoi_line_o` = bits 2..0. Command 7 also sets the rotation offset to that line + 1 (mod 8).
- R11: Command 6 sets the rotation offset to (bits 2..0 + 1) mod 8. Command 2 changes nothing and gives no pulse.
- R12: A read at either address while poll is armed returns 0x80 OR `win_line_i` and pulses `ack_o` with `ack_line_o` = `win_line_i` if `win_valid_i` is set. Otherwise it returns 0x00 with no pulse. Poll is disarmed after that read. If `aeoi_o` and `rot_aeoi_o` are both set, the acknowledge sets the rotation offset to the line + 1 (mod 8).
- R13: Without poll, an address-0 read returns `isr_i` or `irr_i` according to the select, and an address-1 read returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 1 | Register address bit |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| irr_i | input | 8 | Request register from the resolver |
| isr_i | input | 8 | In-service register from the resolver |
| win_valid_i | input | 1 | Resolver has an unmasked winner |
| win_line_i | input | 3 | Winning line |
| isr_top_valid_i | input | 1 | Some line is in service |
| isr_top_line_i | input | 3 | Highest-priority in-service line |
| rdata_o | output | 8 | Read data, combinational |
| imr_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| rot_ofs_o | output | 3 | Rotation offset for the priority scan |
| single_o | output | 1 | Single (non-cascaded) mode |
| sfnm_o | output | 1 | Special fully nested mode |
| aeoi_o | output | 1 | Automatic end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| smm_o | output | 1 | Special mask mode |
| init_clr_o | output | 1 | Pulse: clear request and in-service state |
| eoi_o | output | 1 | Pulse: clear one in-service bit |
| eoi_line_o | output | 3 | Line whose in-service bit to clear |
| ack_o | output | 1 | Pulse: polled acknowledge |
| ack_line_o | output | 3 | Acknowledged line |

## Verification
The hardest case to reach is the rotation of the priority offset on a polled acknowledge. It needs auto-EOI, which only the fourth initialization byte can set, together with rotate-on-auto-EOI, an armed poll and a valid winner, all in place at the moment of the read. The bench reaches it by running a full single-mode sequence that includes the mode byte, then a command 4 byte and a poll-arming byte, and then a read while the winner inputs are held steady. Each initialization path is told apart at the ports alone: an extra address-1 byte either changes the mask or is swallowed as the cascade byte.

// File: rtl/pic_seq_pkg.sv
// Shared types for the interrupt controller command sequencer.
// Assumes: command codes are bits 7..5 of an address-0 byte with bits 4..3 clear.
package pic_seq_pkg;

    typedef enum logic [1:0] {
        STEP_RUN  = 2'd0,
        STEP_BASE = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } step_e;

    localparam logic [2:0] OP_ROT_CLR    = 3'd0;
    localparam logic [2:0] OP_EOI_NS     = 3'd1;
    localparam logic [2:0] OP_NOP        = 3'd2;
    localparam logic [2:0] OP_EOI_SP     = 3'd3;
    localparam logic [2:0] OP_ROT_SET    = 3'd4;
    localparam logic [2:0] OP_EOI_NS_ROT = 3'd5;
    localparam logic [2:0] OP_PRIO_SET   = 3'd6;
    localparam logic [2:0] OP_EOI_SP_ROT = 3'd7;

endpackage

// File: rtl/pic_init_fsm.sv
// Initialization step tracker. It owns the mask, the vector base and the
// modes set at initialization time.
// Assumes: icw1_wr and a1_wr never coincide (they decode different addresses).
module pic_init_fsm
    import pic_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              icw1_wr,
    input  logic              a1_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] imr,
    output logic [DATA_W-1:0] vec_base,
    output logic              single,
    output logic              sfnm,
    output logic              aeoi
);

    localparam int LINE_W = $clog2(DATA_W);

    step_e step_q;
    logic  need4_q;

    // Step register plus the values that the initialization bytes load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= STEP_RUN;
            need4_q  <= 1'b0;
            single   <= 1'b0;
            imr      <= '0;
            vec_base <= '0;
            sfnm     <= 1'b0;
            aeoi     <= 1'b0;
        end else if (icw1_wr) begin
            step_q   <= STEP_BASE;
            need4_q  <= wdata[0];
            single   <= wdata[1];
            imr      <= '0;
            vec_base <= '0;
            sfnm     <= 1'b0;
            aeoi     <= 1'b0;
        end else if (a1_wr) begin
            unique case (step_q)
                STEP_RUN:  imr <= wdata;
                STEP_BASE: begin
                    vec_base <= {wdata[DATA_W-1:LINE_W], {LINE_W{1'b0}}};
                    if (single) step_q <= need4_q ? STEP_MODE : STEP_RUN;
                    else        step_q <= STEP_CASC;
                end
                STEP_CASC: step_q <= need4_q ? STEP_MODE : STEP_RUN;
                STEP_MODE: begin
                    sfnm   <= wdata[4];
                    aeoi   <= wdata[1];
                    step_q <= STEP_RUN;
                end
                default:   step_q <= STEP_RUN;
            endcase
        end
    end

    AST_ICW1_ENTERS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        icw1_wr |=> (step_q == STEP_BASE && imr == '0)); // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (a1_wr && !icw1_wr && step_q == STEP_RUN) |=> imr == $past(wdata)); // R6
    AST_MODE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (a1_wr && !icw1_wr && step_q == STEP_MODE) |=> step_q == STEP_RUN); // R5
    AST_SINGLE_SKIPS_CASC: assert property (@(posedge clk) disable iff (!rst_n)
        (a1_wr && !icw1_wr && step_q == STEP_BASE && single) |=> step_q != STEP_CASC); // R4

endmodule

// File: rtl/pic_ocw_dec.sv
// Run-time command decoder. It covers end-of-interrupt, rotation,
// read select, special mask and poll arming/acknowledge.
// Assumes: resolver inputs are valid in the cycle of the strobe.
module pic_ocw_dec
    import pic_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic                       rd,
    input  logic                       addr,
    input  logic                       icw1_wr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       aeoi,
    input  logic                       isr_top_valid,
    input  logic [$clog2(DATA_W)-1:0]  isr_top_line,
    input  logic                       win_valid,
    input  logic [$clog2(DATA_W)-1:0]  win_line,
    output logic [$clog2(DATA_W)-1:0]  rot_ofs,
    output logic                       rot_aeoi,
    output logic                       smm,
    output logic                       sel_isr,
    output logic                       poll,
    output logic                       eoi,
    output logic [$clog2(DATA_W)-1:0]  eoi_line,
    output logic                       ack,
    output logic [$clog2(DATA_W)-1:0]  ack_line
);

    localparam int LINE_W = $clog2(DATA_W);

    logic              ocw_wr, ocw3_wr, cmd_wr, poll_rd;
    logic [2:0]        cmd;
    logic [LINE_W-1:0] low_line;

    // Classify an address-0 byte that is not an initialization start
    always_comb begin
        ocw_wr   = wr && !addr && !wdata[4];
        ocw3_wr  = ocw_wr && wdata[3];
        cmd_wr   = ocw_wr && !wdata[3];
        cmd      = wdata[7:5];
        low_line = wdata[LINE_W-1:0];
        poll_rd  = rd && poll;
    end

    // End-of-interrupt and acknowledge strobes towards the resolver
    always_comb begin
        eoi      = 1'b0;
        eoi_line = isr_top_line;
        if (cmd_wr) begin
            unique case (cmd)
                OP_EOI_NS, OP_EOI_NS_ROT: eoi = isr_top_valid;
                OP_EOI_SP, OP_EOI_SP_ROT: begin
                    eoi      = 1'b1;
                    eoi_line = low_line;
                end
                default: eoi = 1'b0;
            endcase
        end
        ack      = poll_rd && win_valid;
        ack_line = win_line;
    end

    // Command-driven state: rotation offset, flags and poll
    always_ff @(posedge clk) begin
        if (!rst_n || icw1_wr) begin
            rot_ofs  <= '0;
            rot_aeoi <= 1'b0;
            smm      <= 1'b0;
            sel_isr  <= 1'b0;
            poll     <= 1'b0;
        end else begin
            if (ocw3_wr) begin
                if (wdata[2]) poll    <= 1'b1;
                if (wdata[1]) sel_isr <= wdata[0];
                if (wdata[6]) smm     <= wdata[5];
            end
            if (cmd_wr) begin
                unique case (cmd)
                    OP_ROT_CLR, OP_ROT_SET: rot_aeoi <= cmd[2];
                    OP_EOI_NS_ROT: if (isr_top_valid) rot_ofs <= isr_top_line + LINE_W'(1);
                    OP_PRIO_SET, OP_EOI_SP_ROT: rot_ofs <= low_line + LINE_W'(1);
                    default: ;
                endcase
            end
            if (poll_rd) begin
                poll <= 1'b0;
                if (win_valid && aeoi && rot_aeoi) rot_ofs <= win_line + LINE_W'(1);
            end
        end
    end

    AST_POLL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !ocw3_wr && !icw1_wr) |=> !poll); // R12
    AST_SPEC_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd == OP_EOI_SP_ROT && !poll_rd)
        |=> rot_ofs == LINE_W'($past(wdata[LINE_W-1:0]) + LINE_W'(1))); // R10
    AST_NS_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd == OP_EOI_NS_ROT && !isr_top_valid && !poll_rd) |=> $stable(rot_ofs)); // R9
    AST_STROBES_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && rd) |-> $onehot0({eoi, ack})); // R12

endmodule

// File: rtl/pic_rd_mux.sv
// Read data selection, including the polled response byte.
// Assumes: the poll flag reflects the state before this read.
module pic_rd_mux #(
    parameter int DATA_W = 8
) (
    input  logic                      addr,
    input  logic                      poll,
    input  logic                      sel_isr,
    input  logic                      win_valid,
    input  logic [$clog2(DATA_W)-1:0] win_line,
    input  logic [DATA_W-1:0]         irr,
    input  logic [DATA_W-1:0]         isr,
    input  logic [DATA_W-1:0]         imr,
    output logic [DATA_W-1:0]         rdata
);

    localparam int LINE_W = $clog2(DATA_W);

    // Choose the byte returned to the host
    always_comb begin
        if (poll)      rdata = win_valid ? {1'b1, {(DATA_W-1-LINE_W){1'b0}}, win_line} : '0;
        else if (addr) rdata = imr;
        else           rdata = sel_isr ? isr : irr;
    end

endmodule

// File: rtl/pic_cmd_seq.sv
// Top of the command sequencer. It splits host writes by address and
// bit 4 and wires the step tracker, the command decoder and the read mux.
// Assumes: wr_i and rd_i are not asserted together.
module pic_cmd_seq #(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      addr_i,
    input  logic                      wr_i,
    input  logic                      rd_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [DATA_W-1:0]         irr_i,
    input  logic [DATA_W-1:0]         isr_i,
    input  logic                      win_valid_i,
    input  logic [$clog2(DATA_W)-1:0] win_line_i,
    input  logic                      isr_top_valid_i,
    input  logic [$clog2(DATA_W)-1:0] isr_top_line_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic [DATA_W-1:0]         imr_o,
    output logic [DATA_W-1:0]         vec_base_o,
    output logic [$clog2(DATA_W)-1:0] rot_ofs_o,
    output logic                      single_o,
    output logic                      sfnm_o,
    output logic                      aeoi_o,
    output logic                      rot_aeoi_o,
    output logic                      smm_o,
    output logic                      init_clr_o,
    output logic                      eoi_o,
    output logic [$clog2(DATA_W)-1:0] eoi_line_o,
    output logic                      ack_o,
    output logic [$clog2(DATA_W)-1:0] ack_line_o
);

    logic icw1_wr, a1_wr, sel_isr, poll;

    // Address decode for the two write classes handled here
    always_comb begin
        icw1_wr    = wr_i && !addr_i && wdata_i[4];
        a1_wr      = wr_i && addr_i;
        init_clr_o = icw1_wr;
    end

    pic_init_fsm #(.DATA_W(DATA_W)) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .icw1_wr  (icw1_wr),
        .a1_wr    (a1_wr),
        .wdata    (wdata_i),
        .imr      (imr_o),
        .vec_base (vec_base_o),
        .single   (single_o),
        .sfnm     (sfnm_o),
        .aeoi     (aeoi_o)
    );

    pic_ocw_dec #(.DATA_W(DATA_W)) u_ocw (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (wr_i),
        .rd            (rd_i),
        .addr          (addr_i),
        .icw1_wr       (icw1_wr),
        .wdata         (wdata_i),
        .aeoi          (aeoi_o),
        .isr_top_valid (isr_top_valid_i),
        .isr_top_line  (isr_top_line_i),
        .win_valid     (win_valid_i),
        .win_line      (win_line_i),
        .rot_ofs       (rot_ofs_o),
        .rot_aeoi      (rot_aeoi_o),
        .smm           (smm_o),
        .sel_isr       (sel_isr),
        .poll          (poll),
        .eoi           (eoi_o),
        .eoi_line      (eoi_line_o),
        .ack           (ack_o),
        .ack_line      (ack_line_o)
    );

    pic_rd_mux #(.DATA_W(DATA_W)) u_rd (
        .addr      (addr_i),
        .poll      (poll),
        .sel_isr   (sel_isr),
        .win_valid (win_valid_i),
        .win_line  (win_line_i),
        .irr       (irr_i),
        .isr       (isr_i),
        .imr       (imr_o),
        .rdata     (rdata_o)
    );

    AST_INIT_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr_o |=> (!sfnm_o && !aeoi_o && !smm_o && rot_ofs_o == '0)); // R2
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(vec_base_o) |-> vec_base_o[2:0] == 3'b000); // R3

endmodule

// File: tb/pic_cmd_seq_bench.sv
// Directed bench for the command sequencer: one task per scenario.
module pic_cmd_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0, irr = '0, isr = '0;
    logic       win_valid = 1'b0, top_valid = 1'b0;
    logic [2:0] win_line = '0, top_line = '0;

    logic [7:0] rdata, imr, vbase;
    logic [2:0] rot, eoi_line, ack_line;
    logic       single, sfnm, aeoi, rot_aeoi, smm, init_clr, eoi, ack;

    int n_tests = 0;
    int n_fail  = 0;

    logic       c_init_clr, c_eoi, c_ack;
    logic [2:0] c_eoi_line, c_ack_line;
    logic [7:0] c_rdata;

    pic_cmd_seq u_pic_cmd_seq (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .irr_i(irr), .isr_i(isr),
        .win_valid_i(win_valid), .win_line_i(win_line),
        .isr_top_valid_i(top_valid), .isr_top_line_i(top_line),
        .rdata_o(rdata), .imr_o(imr), .vec_base_o(vbase), .rot_ofs_o(rot),
        .single_o(single), .sfnm_o(sfnm), .aeoi_o(aeoi), .rot_aeoi_o(rot_aeoi),
        .smm_o(smm), .init_clr_o(init_clr), .eoi_o(eoi), .eoi_line_o(eoi_line),
        .ack_o(ack), .ack_line_o(ack_line)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        #1;
        c_init_clr = init_clr; c_eoi = eoi; c_eoi_line = eoi_line;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic a);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1;
        c_rdata = rdata; c_ack = ack; c_ack_line = ack_line;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 imr", imr, 8'h00);
        chk("R1 base", vbase, 8'h00);
        chk("R1 rot", rot, 3'd0);
        chk("R1 flags", {single, sfnm, aeoi, rot_aeoi, smm}, 5'b0);
        do_wr(1'b1, 8'h5A);
        chk("R1 run after reset", imr, 8'h5A);
        do_wr(1'b1, 8'hC3);
        chk("R6 mask load", imr, 8'hC3);
    endtask

    task automatic t_init_full;
        do_wr(1'b0, 8'h11);
        chk("R2 init_clr pulse", c_init_clr, 1'b1);
        chk("R2 mask cleared", imr, 8'h00);
        chk("R2 single flag", single, 1'b0);
        do_wr(1'b1, 8'h47);
        chk("R3 base aligned", vbase, 8'h40);
        chk("R3 mask untouched", imr, 8'h00);
        do_wr(1'b1, 8'hFF);
        chk("R4 cascade byte no effect", {imr, vbase}, {8'h00, 8'h40});
        do_wr(1'b1, 8'h12);
        chk("R5 mode byte", {sfnm, aeoi}, 2'b11);
        do_wr(1'b1, 8'h33);
        chk("R5 back to run", imr, 8'h33);
    endtask

    task automatic t_init_single_no4;
        do_wr(1'b0, 8'h12);
        chk("R2 single set", single, 1'b1);
        chk("R2 modes cleared", {sfnm, aeoi}, 2'b00);
        do_wr(1'b1, 8'h88);
        chk("R3 base", vbase, 8'h88);
        do_wr(1'b1, 8'h0F);
        chk("R4 single no fourth -> run", imr, 8'h0F);
    endtask

    task automatic t_init_single_4;
        do_wr(1'b0, 8'h13);
        do_wr(1'b1, 8'h20);
        do_wr(1'b1, 8'h10);
        chk("R4 single -> mode byte", {imr, sfnm, aeoi}, {8'h00, 2'b10});
        do_wr(1'b1, 8'h01);
        chk("R4 then run", imr, 8'h01);
    endtask

    task automatic t_init_casc_no4;
        irr = 8'hA5; isr = 8'h3C;
        do_wr(1'b0, 8'h0B);
        do_wr(1'b0, 8'h10);
        do_rd(1'b0);
        chk("R2 select back to request", c_rdata, 8'hA5);
        do_wr(1'b1, 8'h08);
        do_wr(1'b1, 8'h04);
        chk("R4 cascade swallowed", imr, 8'h00);
        do_wr(1'b1, 8'h77);
        chk("R4 cascade no fourth -> run", {imr, sfnm}, {8'h77, 1'b0});
    endtask

    task automatic t_ocw3;
        irr = 8'hA5; isr = 8'h3C;
        do_rd(1'b0);
        chk("R13 read request", c_rdata, 8'hA5);
        do_wr(1'b0, 8'h0B);
        do_rd(1'b0);
        chk("R7 select in-service", c_rdata, 8'h3C);
        do_wr(1'b0, 8'h09);
        do_rd(1'b0);
        chk("R7 select kept without bit1", c_rdata, 8'h3C);
        do_wr(1'b0, 8'h0A);
        do_rd(1'b0);
        chk("R7 select request", c_rdata, 8'hA5);
        do_wr(1'b0, 8'h68);
        chk("R7 special mask on", smm, 1'b1);
        do_wr(1'b0, 8'h28);
        chk("R7 special mask kept without bit6", smm, 1'b1);
        do_wr(1'b0, 8'h48);
        chk("R7 special mask off", smm, 1'b0);
        do_rd(1'b1);
        chk("R13 read mask", c_rdata, imr);
    endtask

    task automatic t_rot;
        do_wr(1'b0, 8'h80);
        chk("R8 rotate-on-aeoi set", rot_aeoi, 1'b1);
        do_wr(1'b0, 8'h00);
        chk("R8 rotate-on-aeoi clear", rot_aeoi, 1'b0);
        do_wr(1'b0, 8'hC5);
        chk("R11 priority set", rot, 3'd6);
        do_wr(1'b0, 8'hC7);
        chk("R11 priority wrap", rot, 3'd0);
        do_wr(1'b0, 8'hC2);
        do_wr(1'b0, 8'h47);
        chk("R11 command 2 no change", {rot, c_eoi, rot_aeoi}, {3'd3, 1'b0, 1'b0});
    endtask

    task automatic t_eoi;
        top_valid = 1'b1; top_line = 3'd5;
        do_wr(1'b0, 8'h20);
        chk("R9 nonspecific pulse", {c_eoi, c_eoi_line}, {1'b1, 3'd5});
        chk("R9 command 1 keeps offset", rot, 3'd3);
        do_wr(1'b0, 8'hA0);
        chk("R9 rotate pulse", {c_eoi, c_eoi_line}, {1'b1, 3'd5});
        chk("R9 rotate offset", rot, 3'd6);
        top_valid = 1'b0;
        do_wr(1'b0, 8'hA0);
        chk("R9 nothing in service", {c_eoi, rot}, {1'b0, 3'd6});
        do_wr(1'b0, 8'h62);
        chk("R10 specific pulse", {c_eoi, c_eoi_line, rot}, {1'b1, 3'd2, 3'd6});
        do_wr(1'b0, 8'hE7);
        chk("R10 specific rotate", {c_eoi, c_eoi_line, rot}, {1'b1, 3'd7, 3'd0});
    endtask

    task automatic t_poll;
        do_wr(1'b1, 8'h5C);
        do_wr(1'b0, 8'h0C);
        win_valid = 1'b1; win_line = 3'd4;
        do_rd(1'b1);
        chk("R12 poll response", {c_rdata, c_ack, c_ack_line}, {8'h84, 1'b1, 3'd4});
        do_rd(1'b1);
        chk("R12 poll disarmed", {c_rdata, c_ack}, {8'h5C, 1'b0});
        win_valid = 1'b0;
        do_wr(1'b0, 8'h0C);
        do_rd(1'b0);
        chk("R12 poll empty", {c_rdata, c_ack}, {8'h00, 1'b0});
        irr = 8'h81;
        do_rd(1'b0);
        chk("R13 after empty poll", c_rdata, 8'h81);
        do_wr(1'b0, 8'h13);
        do_wr(1'b1, 8'h00);
        do_wr(1'b1, 8'h02);
        do_wr(1'b0, 8'h80);
        do_wr(1'b0, 8'h0C);
        win_valid = 1'b1; win_line = 3'd6;
        do_rd(1'b0);
        chk("R12 aeoi poll ack", {c_ack, c_ack_line}, {1'b1, 3'd6});
        chk("R12 aeoi rotation", rot, 3'd7);
        win_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_full();
        t_init_single_no4();
        t_init_single_4();
        t_init_casc_no4();
        t_ocw3();
        t_rot();
        t_eoi();
        t_poll();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule